// File: doc/BRIEF.md
# Interrupt Level Masking Arbiter

This block decides which external interrupt request, if any, goes to the trap entry logic of a processor core. Each of the fifteen request lines stands for one priority level from 1 to 15. Every cycle the block compares these lines with the processor's current 4-bit interrupt mask level and with the global trap enable bit. It then presents at most one winner: a valid flag, the winning level, and the trap type code for that level.

Requests are level-sensitive and the block keeps no memory of them. A request that drops before it is taken is lost. Level 15 ignores the mask and acts as a non-maskable interrupt. When traps are disabled, nothing is presented and no error is raised. With the default configuration, every output comes from a register, so the result for the inputs of one cycle appears on the outputs in the next cycle.

Top module: `irq_lvl_arb`

## Requirements
- R1: While rst_ni is low, irq_valid_o, irq_lvl_o and irq_tt_o are all 0, whatever the inputs are.
- R2: When several requests are pending and eligible, irq_lvl_o reports the highest-numbered one. Bit k of irq_req_i is the request for level k, with k from 1 to 15.
- R3: A request whose level is less than or equal to mask_lvl_i is not taken. A request whose level is strictly greater than mask_lvl_i is taken.
- R4: A mask_lvl_i of 0 masks nothing, so a request at any level from 1 to 15 is taken.
- R5: A request at level 15 is taken even when mask_lvl_i is 15.
- R6: While trap_en_i is 0, irq_valid_o is 0 one cycle later, even with eligible requests pending. Presentation resumes one cycle after trap_en_i returns to 1 if the requests are still pending.
- R7: When irq_valid_o is 1, irq_tt_o equals 0x10 plus irq_lvl_o. When irq_valid_o is 0, irq_lvl_o and irq_tt_o are both 0.
- R8: The outputs at a clock edge reflect only the inputs sampled at the previous clock edge. A request removed before it is taken leaves no trace one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 15 | Level-sensitive requests; bit k is level k, k = 1..15 |
| mask_lvl_i | input | 4 | Current processor interrupt mask level |
| trap_en_i | input | 1 | Global trap enable |
| irq_valid_o | output | 1 | An interrupt is presented |
| irq_lvl_o | output | 4 | Level of the presented interrupt, 0 when none |
| irq_tt_o | output | 8 | Trap type, 0x10 plus the level, 0 when none |

## Verification
Single requests are swept across every mask value. This separates a strictly-greater comparison from a greater-or-equal one and shows that level 15 alone gets past a mask of 15. Multi-bit request patterns with mask values between the pending levels show that the highest eligible level wins, and that a masked top request does not let a lower one through. Toggling trap_en_i, and dropping requests between cycles, shows that nothing is latched. A long pseudo-random sequence of all three inputs is compared every cycle against a behavioural model.

// File: rtl/irq_lvl_arb_pkg.sv
package irq_lvl_arb_pkg;
  localparam int unsigned DEF_NUM_LEVELS = 16;
  localparam int unsigned DEF_TT_W       = 8;
  localparam int unsigned DEF_TT_BASE    = 16;
endpackage

// File: rtl/irq_elig_gate.sv
// Per-level eligibility: pending, above the mask (or NMI), traps on.
module irq_elig_gate #(
  parameter int unsigned NUM_LEVELS = irq_lvl_arb_pkg::DEF_NUM_LEVELS,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:1] req_i,
  input  logic [LVL_W-1:0]      mask_i,
  input  logic                  en_i,
  output logic [NUM_LEVELS-1:0] elig_o
);
  localparam int unsigned NMI_LVL = NUM_LEVELS - 1;

  assign elig_o[0] = 1'b0;

  for (genvar l = 1; l < NUM_LEVELS; l++) begin : g_lvl
    if (l == NMI_LVL) begin : g_nmi
      assign elig_o[l] = en_i & req_i[l];
    end else begin : g_mask
      assign elig_o[l] = en_i & req_i[l] & (LVL_W'(l) > mask_i);
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
// Highest set bit wins.
module irq_prio_enc #(
  parameter int unsigned N = irq_lvl_arb_pkg::DEF_NUM_LEVELS,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_tt_map.sv
module irq_tt_map #(
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned TT_W    = irq_lvl_arb_pkg::DEF_TT_W,
  parameter int unsigned TT_BASE = irq_lvl_arb_pkg::DEF_TT_BASE
) (
  input  logic             valid_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [TT_W-1:0]  tt_o
);
  assign lvl_o = valid_i ? lvl_i : '0;
  assign tt_o  = valid_i ? (TT_W'(TT_BASE) + TT_W'(lvl_i)) : '0;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned W       = 13,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb #(
  parameter int unsigned NUM_LEVELS = irq_lvl_arb_pkg::DEF_NUM_LEVELS,
  parameter int unsigned TT_W       = irq_lvl_arb_pkg::DEF_TT_W,
  parameter int unsigned TT_BASE    = irq_lvl_arb_pkg::DEF_TT_BASE,
  parameter bit          OUT_REG    = 1'b1,
  localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:1] irq_req_i,
  input  logic [LVL_W-1:0]      mask_lvl_i,
  input  logic                  trap_en_i,
  output logic                  irq_valid_o,
  output logic [LVL_W-1:0]      irq_lvl_o,
  output logic [TT_W-1:0]       irq_tt_o
);
  localparam int unsigned OUT_W = 1 + LVL_W + TT_W;

  logic [NUM_LEVELS-1:0] elig;
  logic                  win_vld;
  logic [LVL_W-1:0]      win_lvl, lvl_n;
  logic [TT_W-1:0]       tt_n;
  logic [OUT_W-1:0]      out_q;

  irq_elig_gate #(.NUM_LEVELS(NUM_LEVELS)) u_gate (
    .req_i (irq_req_i),
    .mask_i(mask_lvl_i),
    .en_i  (trap_en_i),
    .elig_o(elig)
  );

  irq_prio_enc #(.N(NUM_LEVELS)) u_enc (
    .vec_i  (elig),
    .found_o(win_vld),
    .idx_o  (win_lvl)
  );

  irq_tt_map #(.LVL_W(LVL_W), .TT_W(TT_W), .TT_BASE(TT_BASE)) u_tt (
    .valid_i(win_vld),
    .lvl_i  (win_lvl),
    .lvl_o  (lvl_n),
    .tt_o   (tt_n)
  );

  irq_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({win_vld, lvl_n, tt_n}),
    .q_o   (out_q)
  );

  assign {irq_valid_o, irq_lvl_o, irq_tt_o} = out_q;
endmodule

// File: rtl/irq_lvl_arb_chk.sv
module irq_lvl_arb_chk #(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned TT_W       = 8,
  parameter int unsigned TT_BASE    = 16,
  parameter bit          OUT_REG    = 1'b1,
  localparam int unsigned LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_LEVELS-1:1] irq_req_i,
  input logic [LVL_W-1:0]      mask_lvl_i,
  input logic                  trap_en_i,
  input logic                  irq_valid_o,
  input logic [LVL_W-1:0]      irq_lvl_o,
  input logic [TT_W-1:0]       irq_tt_o
);
  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (!irq_valid_o && irq_lvl_o == '0 && irq_tt_o == '0);
  end

  assert_tt_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_tt_o == TT_W'(TT_BASE) + TT_W'(irq_lvl_o));

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> (irq_lvl_o == '0 && irq_tt_o == '0));

  if (OUT_REG) begin : g_seq
    assert_trap_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trap_en_i |=> !irq_valid_o);

    assert_nmi_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_en_i && irq_req_i[NUM_LEVELS-1]) |=> (irq_valid_o && irq_lvl_o == LVL_W'(NUM_LEVELS-1)));

    assert_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_i == '0) |=> !irq_valid_o);

    assert_above_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_en_i && !irq_req_i[NUM_LEVELS-1]) |=>
        (!irq_valid_o || irq_lvl_o > $past(mask_lvl_i)));
  end
endmodule

bind irq_lvl_arb irq_lvl_arb_chk #(
  .NUM_LEVELS(NUM_LEVELS), .TT_W(TT_W), .TT_BASE(TT_BASE), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_req_i  (irq_req_i),
  .mask_lvl_i (mask_lvl_i),
  .trap_en_i  (trap_en_i),
  .irq_valid_o(irq_valid_o),
  .irq_lvl_o  (irq_lvl_o),
  .irq_tt_o   (irq_tt_o)
);

// File: tb/sim_irq_lvl_arb.sv
`timescale 1ns/1ps
module sim_irq_lvl_arb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:1] irq_req_i = '0;
  logic [3:0]  mask_lvl_i = '0;
  logic        trap_en_i = 1'b0;
  logic        irq_valid_o;
  logic [3:0]  irq_lvl_o;
  logic [7:0]  irq_tt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_lvl_arb u0 (.*);

  // behavioural expectation from sampled inputs
  function automatic void model(input logic [15:1] req, input int mask, input bit en,
                                output bit v, output int lvl, output int tt);
    int top;
    top = 0;
    for (int l = 1; l <= 15; l++) if (req[l]) top = l;
    v   = en && top != 0 && (top > mask || top == 15);
    lvl = v ? top : 0;
    tt  = v ? 16 + top : 0;
  endfunction

  task automatic chk(input string tag, input bit ev, input int el, input int et);
    checks++;
    if (irq_valid_o !== ev || int'(irq_lvl_o) != el || int'(irq_tt_o) != et) begin
      failures++;
      $display("FAIL %s: got v=%0b l=%0d tt=%0h exp v=%0b l=%0d tt=%0h",
               tag, irq_valid_o, irq_lvl_o, irq_tt_o, ev, el, et);
    end
  endtask

  // drive at negedge, output updates at next posedge, sample at following negedge
  task automatic step(input string tag, input logic [15:1] req, input int mask, input bit en);
    bit v; int l; int t;
    @(negedge clk_i);
    irq_req_i = req; mask_lvl_i = 4'(mask); trap_en_i = en;
    model(req, mask, en, v, l, t);
    @(negedge clk_i);
    chk(tag, v, l, t);
  endtask

  initial begin
    int unsigned lfsr;
    irq_req_i = 15'h7fff; trap_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1", 1'b0, 0, 0);
    rst_ni = 1'b1;
    irq_req_i = '0;

    // single request sweep against every mask: R3/R4/R5
    for (int lv = 1; lv <= 15; lv++)
      for (int m = 0; m <= 15; m++)
        step(lv == 15 ? "R5" : (m == 0 ? "R4" : "R3"), 15'(1) << (lv - 1), m, 1'b1);

    // priority: R2
    step("R2", 15'b000_0000_0010_0101, 0, 1'b1);
    step("R2", 15'b100_0000_0000_0001, 0, 1'b1);
    step("R2", 15'b011_1111_1111_1111, 3, 1'b1);
    step("R2", 15'b000_0001_0001_0000, 5, 1'b1);
    step("R3", 15'b000_0001_0001_0000, 9, 1'b1);
    step("R5", 15'b111_1111_1111_1111, 15, 1'b1);

    // trap enable: R6
    step("R6", 15'h7fff, 0, 1'b0);
    step("R6", 15'h4000, 15, 1'b0);
    step("R6", 15'h0080, 2, 1'b1);

    // no latching: R8
    step("R8", 15'h0010, 0, 1'b1);
    step("R8", 15'h0000, 0, 1'b1);
    step("R8", 15'h0200, 12, 1'b1);
    step("R8", 15'h0000, 12, 1'b1);

    // random sweep: R7 trap type code
    lfsr = 32'h1ace_b00c;
    for (int i = 0; i < 2000; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step("R7", lfsr[14:0], int'(lfsr[19:16]), lfsr[23:20] != 4'h0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule